// File: doc/BRIEF.md
# Operand Forwarding Selector

This block decides, for the instruction now in the execute stage of a five-stage in-order pipeline, where each source operand should come from. The candidates are the value read from the register file, the result held in the execute/memory pipeline register, and the result held in the memory/writeback pipeline register. The block is purely combinational. Its select codes settle in the same cycle as its inputs, so the operand multiplexers are steered before the ALU computes.

The operands that are inspected depend on the instruction class. Register-register operations compare both sources. Immediate, load and store operations compare only the first source. A branch compares both of its comparison registers, and its result is reported on a separate pair of comparator selects. When both later stages write the register that is needed, the younger result wins. A producer counts only if its write enable is set and its destination is not register zero. Older results, three or more instructions back, need no path of their own, because the register file writes early in the cycle and reads late.

Top module: `fwd_unit`

## Requirements
- R1: For a register-register class (code 3'd0), a first source that equals the execute/memory destination drives `alu_sel_a_o` to 2'b10. 2'b10 is the select code for the execute/memory result.
- R2: For the register-register class, the second source is checked as well. A second source that matches only the memory/writeback destination gives `alu_sel_b_o` = 2'b01, and a match on the execute/memory destination gives 2'b10.
- R3: When the execute/memory and memory/writeback destinations both equal the same source, the select for that source is 2'b10 and never 2'b01.
- R4: For the immediate (3'd1), load (3'd2) and store (3'd3) classes, only the first source is forwarded. `alu_sel_b_o` stays 2'b00 (register file) whatever the second source matches.
- R5: For the branch class (3'd4), both sources are forwarded on `cmp_sel_a_o` / `cmp_sel_b_o` with the same codes, and both ALU selects are 2'b00. For every non-branch class, both comparator selects are 2'b00.
- R6: A stage whose write enable is low never produces a match. If only the memory/writeback stage is enabled and matching, its code 2'b01 is used.
- R7: A source register number of zero always selects 2'b00, even when an enabled destination is also zero.
- R8: With no enabled matching destination, every select is 2'b00, including the all-zero input state. This covers a dependence three instructions back.
- R9: Class codes 3'd5 to 3'd7 forward nothing, and all four selects are 2'b00.
- R10: No select output ever carries the code 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_i | input | AW | First source register number of the instruction in execute |
| src_b_i | input | AW | Second source register number of the instruction in execute |
| cls_i | input | 3 | Instruction class code |
| exm_dst_i | input | AW | Destination register held in the execute/memory stage |
| exm_we_i | input | 1 | Register-write enable of the execute/memory stage |
| mwb_dst_i | input | AW | Destination register held in the memory/writeback stage |
| mwb_we_i | input | 1 | Register-write enable of the memory/writeback stage |
| alu_sel_a_o | output | 2 | Select for the ALU first operand |
| alu_sel_b_o | output | 2 | Select for the ALU second operand |
| cmp_sel_a_o | output | 2 | Select for the branch comparator first operand |
| cmp_sel_b_o | output | 2 | Select for the branch comparator second operand |

## Verification
The bench drives three successive writes to one register so that both later stages match. A design that ranked the stages the wrong way round would return the stale memory/writeback code 2'b01 there. It also gives immediate, load and store instructions a second source that matches a live destination; a design that ignored the class would forward a field that is not a register. Disabled writers, register zero and unused class codes are each probed while a destination matches, so a missing enable term, a missing zero guard or an over-broad class decode shows up as a spurious nonzero select. Branch cases confirm that forwarding moves from the ALU selects to the comparator selects.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int CLS_W  = 3;
    localparam int SEL_W  = 2;
    localparam int NUM_OP = 2;

    typedef enum logic [CLS_W-1:0] {
        IC_RR     = 3'd0,
        IC_IMM    = 3'd1,
        IC_LOAD   = 3'd2,
        IC_STORE  = 3'd3,
        IC_BRANCH = 3'd4
    } iclass_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_RF  = 2'b00,
        SEL_MWB = 2'b01,
        SEL_EXM = 2'b10
    } fsel_e;

    typedef struct packed {
        logic [NUM_OP-1:0] need;
        logic              to_cmp;
    } cls_use_t;

    typedef struct packed {
        fsel_e [NUM_OP-1:0] alu;
        fsel_e [NUM_OP-1:0] cmp;
    } route_t;

endpackage

// File: rtl/fwd_class_decode.sv
module fwd_class_decode
    import fwd_pkg::*;
(
    input  logic [CLS_W-1:0] cls_i,
    output cls_use_t         use_o
);
    always_comb begin
        use_o = '0;
        case (cls_i)
            IC_RR:     use_o.need = 2'b11;
            IC_IMM,
            IC_LOAD,
            IC_STORE:  use_o.need = 2'b01;
            IC_BRANCH: begin
                use_o.need   = 2'b11;
                use_o.to_cmp = 1'b1;
            end
            default:   use_o = '0;
        endcase
    end
endmodule

// File: rtl/fwd_hit.sv
module fwd_hit #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic          we_i,
    output logic          hit_o
);
    always_comb begin
        hit_o = we_i && (src_i != '0) && (src_i == dst_i);
    end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
    import fwd_pkg::*;
(
    input  logic  use_i,
    input  logic  hit_exm_i,
    input  logic  hit_mwb_i,
    output fsel_e sel_o
);
    always_comb begin
        sel_o = SEL_RF;
        if (use_i) begin
            if (hit_exm_i)      sel_o = SEL_EXM;
            else if (hit_mwb_i) sel_o = SEL_MWB;
        end
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0]    src_a_i,
    input  logic [AW-1:0]    src_b_i,
    input  logic [CLS_W-1:0] cls_i,
    input  logic [AW-1:0]    exm_dst_i,
    input  logic             exm_we_i,
    input  logic [AW-1:0]    mwb_dst_i,
    input  logic             mwb_we_i,
    output logic [SEL_W-1:0] alu_sel_a_o,
    output logic [SEL_W-1:0] alu_sel_b_o,
    output logic [SEL_W-1:0] cmp_sel_a_o,
    output logic [SEL_W-1:0] cmp_sel_b_o
);
    cls_use_t               cls_use;
    logic [AW-1:0]          src     [NUM_OP];
    logic [NUM_OP-1:0]      hit_exm;
    logic [NUM_OP-1:0]      hit_mwb;
    fsel_e [NUM_OP-1:0]     pick;
    route_t                 route_d;

    assign src[0] = src_a_i;
    assign src[1] = src_b_i;

    fwd_class_decode u_dec (
        .cls_i (cls_i),
        .use_o (cls_use)
    );

    for (genvar g = 0; g < NUM_OP; g++) begin : g_op
        fwd_hit #(.AW(AW)) u_hit_exm (
            .src_i (src[g]),
            .dst_i (exm_dst_i),
            .we_i  (exm_we_i),
            .hit_o (hit_exm[g])
        );
        fwd_hit #(.AW(AW)) u_hit_mwb (
            .src_i (src[g]),
            .dst_i (mwb_dst_i),
            .we_i  (mwb_we_i),
            .hit_o (hit_mwb[g])
        );
        fwd_pick u_pick (
            .use_i     (cls_use.need[g]),
            .hit_exm_i (hit_exm[g]),
            .hit_mwb_i (hit_mwb[g]),
            .sel_o     (pick[g])
        );
    end

    always_comb begin
        route_d = '{alu: {SEL_RF, SEL_RF}, cmp: {SEL_RF, SEL_RF}};
        for (int i = 0; i < NUM_OP; i++) begin
            if (cls_use.to_cmp) route_d.cmp[i] = pick[i];
            else                route_d.alu[i] = pick[i];
        end
    end

    assign alu_sel_a_o = route_d.alu[0];
    assign alu_sel_b_o = route_d.alu[1];
    assign cmp_sel_a_o = route_d.cmp[0];
    assign cmp_sel_b_o = route_d.cmp[1];

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input logic [AW-1:0]    src_a_i,
    input logic [AW-1:0]    src_b_i,
    input logic [CLS_W-1:0] cls_i,
    input logic [AW-1:0]    exm_dst_i,
    input logic             exm_we_i,
    input logic [AW-1:0]    mwb_dst_i,
    input logic             mwb_we_i,
    input logic [SEL_W-1:0] alu_sel_a_o,
    input logic [SEL_W-1:0] alu_sel_b_o,
    input logic [SEL_W-1:0] cmp_sel_a_o,
    input logic [SEL_W-1:0] cmp_sel_b_o
);
    always_comb begin
        // R3: the younger stage outranks the older one on a shared register
        a_r3_young_wins: assert (!(cls_i == IC_RR && exm_we_i && mwb_we_i &&
                                   src_a_i != '0 && src_a_i == exm_dst_i &&
                                   src_a_i == mwb_dst_i) || alu_sel_a_o == 2'b10)
            else $error("a_r3_young_wins");
        // R4: second source untouched for single-source classes
        a_r4_b_idle: assert (!(cls_i == IC_IMM || cls_i == IC_LOAD || cls_i == IC_STORE) ||
                             alu_sel_b_o == 2'b00)
            else $error("a_r4_b_idle");
        // R5: branch forwarding lives on the comparator selects only
        a_r5_split: assert ((cls_i == IC_BRANCH) ?
                            (alu_sel_a_o == 2'b00 && alu_sel_b_o == 2'b00) :
                            (cmp_sel_a_o == 2'b00 && cmp_sel_b_o == 2'b00))
            else $error("a_r5_split");
        // R6: with both writers disabled nothing is forwarded
        a_r6_no_writer: assert (exm_we_i || mwb_we_i ||
                                (alu_sel_a_o == 2'b00 && alu_sel_b_o == 2'b00 &&
                                 cmp_sel_a_o == 2'b00 && cmp_sel_b_o == 2'b00))
            else $error("a_r6_no_writer");
        // R7: register zero always reads the register file
        a_r7_zero_src: assert (src_a_i != '0 ||
                               (alu_sel_a_o == 2'b00 && cmp_sel_a_o == 2'b00))
            else $error("a_r7_zero_src");
        // R9: unused class codes forward nothing
        a_r9_unused_cls: assert (cls_i <= IC_BRANCH ||
                                 (alu_sel_a_o == 2'b00 && alu_sel_b_o == 2'b00 &&
                                  cmp_sel_a_o == 2'b00 && cmp_sel_b_o == 2'b00))
            else $error("a_r9_unused_cls");
        // R10: code 2'b11 never appears
        a_r10_legal_code: assert (alu_sel_a_o != 2'b11 && alu_sel_b_o != 2'b11 &&
                                  cmp_sel_a_o != 2'b11 && cmp_sel_b_o != 2'b11)
            else $error("a_r10_legal_code");
    end
endmodule

bind fwd_unit fwd_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/fwd_unit_test.sv
`timescale 1ns/1ps
module fwd_unit_test;
    localparam int AW = 5;

    typedef struct {
        logic [1:0] aa, ab, ca, cb;
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic [AW-1:0] src_a, src_b, exm_dst, mwb_dst;
    logic [2:0]    cls;
    logic          exm_we, mwb_we;
    logic [1:0]    alu_a, alu_b, cmp_a, cmp_b;

    int   checks   = 0;
    int   failures = 0;
    bit   done     = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    fwd_unit #(.AW(AW)) uut (
        .src_a_i     (src_a),
        .src_b_i     (src_b),
        .cls_i       (cls),
        .exm_dst_i   (exm_dst),
        .exm_we_i    (exm_we),
        .mwb_dst_i   (mwb_dst),
        .mwb_we_i    (mwb_we),
        .alu_sel_a_o (alu_a),
        .alu_sel_b_o (alu_b),
        .cmp_sel_a_o (cmp_a),
        .cmp_sel_b_o (cmp_b)
    );

    task automatic drive(input logic [2:0] c, input int a, input int b,
                         input int ed, input logic ew, input int md, input logic mw,
                         input logic [1:0] eaa, input logic [1:0] eab,
                         input logic [1:0] eca, input logic [1:0] ecb, input string tag);
        exp_t e;
        @(posedge clk);
        cls = c; src_a = AW'(a); src_b = AW'(b);
        exm_dst = AW'(ed); exm_we = ew; mwb_dst = AW'(md); mwb_we = mw;
        e.aa = eaa; e.ab = eab; e.ca = eca; e.cb = ecb; e.tag = tag;
        sb.push_back(e);
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (alu_a !== e.aa || alu_b !== e.ab || cmp_a !== e.ca || cmp_b !== e.cb) begin
                failures++;
                $display("FAIL %s: actual alu=%b/%b cmp=%b/%b expected alu=%b/%b cmp=%b/%b",
                         e.tag, alu_a, alu_b, cmp_a, cmp_b, e.aa, e.ab, e.ca, e.cb);
            end
        end
    end

    initial begin
        cls = '0; src_a = '0; src_b = '0; exm_dst = '0; mwb_dst = '0;
        exm_we = 1'b0; mwb_we = 1'b0;
        repeat (2) @(posedge clk);
        // R8: all-zero state
        drive(0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 2'b00, 2'b00, "R8 idle");
        // R1
        drive(0, 3, 4, 3, 1, 9, 1, 2'b10, 2'b00, 2'b00, 2'b00, "R1 rs from exm");
        // R2
        drive(0, 5, 6, 7, 1, 6, 1, 2'b00, 2'b01, 2'b00, 2'b00, "R2 rt from mwb");
        drive(0, 6, 6, 6, 1, 1, 1, 2'b10, 2'b10, 2'b00, 2'b00, "R2 rt from exm");
        // R3: three back-to-back writes to register 10
        drive(0, 10, 12, 10, 1, 10, 1, 2'b10, 2'b00, 2'b00, 2'b00, "R3 chain rs");
        drive(0, 2, 10, 10, 1, 10, 1, 2'b00, 2'b10, 2'b00, 2'b00, "R3 chain rt");
        // R4
        drive(1, 8, 9, 9, 1, 9, 1, 2'b00, 2'b00, 2'b00, 2'b00, "R4 imm rt ignored");
        drive(1, 8, 9, 3, 1, 8, 1, 2'b01, 2'b00, 2'b00, 2'b00, "R4 imm rs mwb");
        drive(2, 4, 4, 4, 1, 0, 0, 2'b10, 2'b00, 2'b00, 2'b00, "R4 load");
        drive(3, 1, 2, 3, 1, 2, 1, 2'b00, 2'b00, 2'b00, 2'b00, "R4 store rt ignored");
        drive(3, 2, 5, 3, 1, 2, 1, 2'b01, 2'b00, 2'b00, 2'b00, "R4 store rs mwb");
        // R5
        drive(4, 7, 8, 8, 1, 7, 1, 2'b00, 2'b00, 2'b01, 2'b10, "R5 branch split");
        drive(4, 7, 7, 7, 1, 7, 1, 2'b00, 2'b00, 2'b10, 2'b10, "R5 branch prio");
        // R6
        drive(0, 3, 4, 3, 0, 3, 1, 2'b01, 2'b00, 2'b00, 2'b00, "R6 exm disabled");
        drive(0, 3, 4, 3, 0, 4, 0, 2'b00, 2'b00, 2'b00, 2'b00, "R6 both disabled");
        // R7
        drive(0, 0, 0, 0, 1, 0, 1, 2'b00, 2'b00, 2'b00, 2'b00, "R7 zero rr");
        drive(4, 0, 5, 0, 1, 5, 1, 2'b00, 2'b00, 2'b00, 2'b01, "R7 zero branch");
        // R8: dependence three back is gone from both stages
        drive(0, 11, 12, 13, 1, 14, 1, 2'b00, 2'b00, 2'b00, 2'b00, "R8 no match");
        // R9
        drive(5, 3, 3, 3, 1, 3, 1, 2'b00, 2'b00, 2'b00, 2'b00, "R9 class 5");
        drive(7, 3, 4, 3, 1, 4, 1, 2'b00, 2'b00, 2'b00, 2'b00, "R9 class 7");
        // R10: all-ones register numbers
        drive(0, 31, 31, 31, 1, 31, 1, 2'b10, 2'b10, 2'b00, 2'b00, "R10 top register");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule